// File: doc/BRIEF.md
# Programmable Interval Timer with Interrupt Shaping

This block counts down an 8-bit value at one of four selectable tick rates and raises a timer interrupt when the count reaches zero. The ticks arrive as single-cycle strobes from a divider that sits outside the block. The reload value sits in its own register, which the countdown never changes. The live count is returned on a separate output. A sticky flag records each expiry. The interrupt output is an active-low drive enable, `irq_drive_low`: when it is high, the pad is pulled low, and when it is low, the pad floats.

The block has two modes. In level mode the timer counts once and stops at zero. The interrupt stays asserted until software clears the flag. In periodic mode the interrupt releases itself after half a period of a reference divider stage. At that same moment the count reloads and the timer starts again. The register file and bus decode sit outside the block. They drive the write strobes and the held configuration bits.

Top module: `interval_timer_irq`

## Requirements
- R1: `src_sel` picks the counting strobe from `src_tick`: code 00 selects bit 0 (4096 Hz), 01 selects bit 1 (64 Hz), 10 selects bit 2 (1 Hz) and 11 selects bit 3 (one per minute). Strobes on unselected bits do not change the count.
- R2: A write on `preset_we` sets `preset_q` and `count_q` to `preset_wdata` one cycle later. After that, `preset_q` changes only on another preset write.
- R3: Writing 1 to the enable starts the timer. The first selected strobe after the start only arms the counter, and every later selected strobe lowers the count by one. While the enable is 0, the count holds.
- R4: When the count steps from 1 to 0, `flag_q` is set. A flag write with data 0 clears it, and a flag write with data 1 leaves it unchanged. When an expiry and a clear fall in the same cycle, the expiry wins.
- R5: In level mode (`periodic_mode` = 0), an expiry clears `te_q` and the count stays at 0. The exception is a timer that was started while the flag was 1: in that case `te_q` stays 1.
- R6: In level mode, `irq_drive_low` equals the flag while `irq_en` is 1.
- R7: In periodic mode, an expiry asserts `irq_drive_low`. It is released on the first release strobe after the expiry cycle, and the count reloads from `preset_q` on that same strobe. The release strobe is `half_fast` when `src_sel` is 00 and `half_slow` for every other code. The flag stays set.
- R8: While `irq_en` is 0, `irq_drive_low` is 0 whatever the flag holds.
- R9: With a preset of zero, a running timer never expires and never sets the flag.
- R10: A start followed by a stop with no selected strobe between them leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 4 | Source strobes, one bit per rate, each one cycle wide |
| half_fast | input | 1 | Strobe at the midpoint of each 4096 Hz period |
| half_slow | input | 1 | Strobe at the midpoint of each 64 Hz period |
| src_sel | input | 2 | Source rate select |
| periodic_mode | input | 1 | 1 selects periodic auto-return mode, 0 selects level mode |
| irq_en | input | 1 | Interrupt output enable |
| preset_we | input | 1 | Preset write strobe |
| preset_wdata | input | 8 | Preset write data |
| te_we | input | 1 | Enable write strobe |
| te_wdata | input | 1 | Enable write data |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data (only 0 has an effect) |
| preset_q | output | 8 | Stored preset value |
| count_q | output | 8 | Live count |
| te_q | output | 1 | Timer enable state |
| flag_q | output | 1 | Sticky expiry flag |
| irq_drive_low | output | 1 | 1 pulls the interrupt pad low, 0 floats it |

## Verification
The bench goes after the following corner cases:

- **Arming on start.** A start and a stop with no selected tick between them must leave the count as it was. A design that decrements on the first tick after a start would lose a count here.
- **Flag writes.** A flag write with data 1 must leave the flag unchanged. A design that stored the written value would set the flag by software.
- **Start with the flag already set.** A timer started while the flag is 1 must keep running after it expires. A design that always cleared the enable at expiry would stop it.
- **Release strobe selection.** In periodic mode the output must ignore the wrong release strobe for the selected source. A design that used either strobe would release early.
- **Reload timing.** The reload must happen on the release cycle. A design that reloaded at expiry would show a count other than zero while the interrupt is still asserted.
- **Zero preset.** A preset of zero must never expire. A design that wrapped the count from 0 would raise spurious interrupts.

// File: rtl/pit_pkg.sv
// Package: shared types and constants for the interval timer.
// Assumes a source-select code equals the bit index into the tick vector.
package pit_pkg;
    typedef enum logic [1:0] {
        SRC_4K  = 2'b00,
        SRC_64  = 2'b01,
        SRC_1HZ = 2'b10,
        SRC_MIN = 2'b11
    } pit_src_e;

    localparam int PIT_NUM_SRC = 4;
    localparam int PIT_SEL_W   = $clog2(PIT_NUM_SRC);
endpackage

// File: rtl/pit_tick_select.sv
// Module: picks the counting strobe and the release strobe from the source select.
// Assumes the strobes are one cycle wide and already in the clk domain.
// The fast release strobe serves only the fastest source, code 0.
module pit_tick_select
    import pit_pkg::*;
#(
    parameter int NUM_SRC = PIT_NUM_SRC,
    parameter int SEL_W   = PIT_SEL_W
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               half_fast,
    input  logic               half_slow,
    input  logic [SEL_W-1:0]   src_sel,
    output logic               sel_tick,
    output logic               rel_strobe
);
    // Multiplexes the selected tick by index.
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_sel == SEL_W'(i)) sel_tick = src_tick[i];
        end
    end

    // Chooses the half-period release strobe that matches the source class.
    always_comb begin
        rel_strobe = (src_sel == SEL_W'(SRC_4K)) ? half_fast : half_slow;
    end
endmodule

// File: rtl/pit_countdown.sv
// Module: preset register, down-counter, enable, sticky flag and the periodic
// release-pending state.
// Assumes that the write strobes are one cycle wide, that a preset write wins
// over a decrement or reload, and that an expiry wins over a flag clear.
module pit_countdown #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_tick,
    input  logic             rel_strobe,
    input  logic             periodic_mode,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_wdata,
    input  logic             te_we,
    input  logic             te_wdata,
    input  logic             flag_we,
    input  logic             flag_wdata,
    output logic [CNT_W-1:0] preset_q,
    output logic [CNT_W-1:0] count_q,
    output logic             te_q,
    output logic             flag_q,
    output logic             pend_q
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic armed_q;
    logic startf_q;
    logic start_req;
    logic stop_req;
    logic dec_en;
    logic expire;
    logic reload;

    assign start_req = te_we & te_wdata & ~te_q;
    assign stop_req  = te_we & ~te_wdata;
    assign dec_en    = te_q & armed_q & sel_tick & (count_q != CNT_ZERO) & ~preset_we;
    assign expire    = dec_en & (count_q == CNT_ONE);
    assign reload    = pend_q & rel_strobe & ~preset_we;

    // Holds the software preset; only a preset write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         preset_q <= '0;
        else if (preset_we) preset_q <= preset_wdata;
    end

    // Live count: load on a preset write, reload on release, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n)         count_q <= '0;
        else if (preset_we) count_q <= preset_wdata;
        else if (reload)    count_q <= preset_q;
        else if (dec_en)    count_q <= count_q - CNT_ONE;
    end

    // Timer enable: software start and stop, and the self-clear in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      te_q <= 1'b0;
        else if (start_req)                              te_q <= 1'b1;
        else if (stop_req)                               te_q <= 1'b0;
        else if (expire && !periodic_mode && !startf_q)  te_q <= 1'b0;
    end

    // Arms on the first selected tick after a start, so part periods count nothing.
    always_ff @(posedge clk) begin
        if (!rst_n)                     armed_q <= 1'b0;
        else if (start_req || stop_req) armed_q <= 1'b0;
        else if (te_q && sel_tick)      armed_q <= 1'b1;
    end

    // Records whether the flag was already set at the moment of the start.
    always_ff @(posedge clk) begin
        if (!rst_n)         startf_q <= 1'b0;
        else if (start_req) startf_q <= flag_q;
    end

    // Sticky flag: set on expiry, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (expire)                 flag_q <= 1'b1;
        else if (flag_we && !flag_wdata) flag_q <= 1'b0;
    end

    // Periodic release pending: set on expiry, cleared by the release strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend_q <= 1'b0;
        else if (expire && periodic_mode) pend_q <= 1'b1;
        else if (rel_strobe)              pend_q <= 1'b0;
    end

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        preset_we |=> (count_q == $past(preset_wdata)) && (preset_q == $past(preset_wdata))); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en && !reload |=> count_q == CNT_W'($past(count_q) - CNT_ONE)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !te_q && !preset_we && !reload |=> $stable(count_q)); // R3
    AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !(flag_we && !flag_wdata) |=> flag_q); // R4
    AST_LEVEL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !periodic_mode && !startf_q && !te_we |=> !te_q); // R5
    AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && rel_strobe && !(expire && periodic_mode) |=> !pend_q); // R7
    AST_ZERO_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q == CNT_ZERO |=> !$rose(flag_q)); // R9
endmodule

// File: rtl/pit_irq_shape.sv
// Module: forms the active-low drive enable from the flag or the release-pending state.
// Assumes that pend is only ever set in periodic mode.
module pit_irq_shape (
    input  logic flag_q,
    input  logic pend_q,
    input  logic periodic_mode,
    input  logic irq_en,
    output logic irq_drive_low
);
    // Level mode follows the flag; periodic mode follows the pending pulse.
    always_comb begin
        irq_drive_low = irq_en & (periodic_mode ? pend_q : flag_q);
    end
endmodule

// File: rtl/interval_timer_irq.sv
// Module: top of the interval timer; joins the tick select, the counter and the output shaping.
// Assumes that the source and release strobes come from an external divider in the clk domain.
module interval_timer_irq
    import pit_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NUM_SRC = PIT_NUM_SRC,
    parameter int SEL_W   = PIT_SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               half_fast,
    input  logic               half_slow,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               periodic_mode,
    input  logic               irq_en,
    input  logic               preset_we,
    input  logic [CNT_W-1:0]   preset_wdata,
    input  logic               te_we,
    input  logic               te_wdata,
    input  logic               flag_we,
    input  logic               flag_wdata,
    output logic [CNT_W-1:0]   preset_q,
    output logic [CNT_W-1:0]   count_q,
    output logic               te_q,
    output logic               flag_q,
    output logic               irq_drive_low
);
    logic sel_tick;
    logic rel_strobe;
    logic pend_q;

    pit_tick_select #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
        .src_tick   (src_tick),
        .half_fast  (half_fast),
        .half_slow  (half_slow),
        .src_sel    (src_sel),
        .sel_tick   (sel_tick),
        .rel_strobe (rel_strobe)
    );

    pit_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_tick      (sel_tick),
        .rel_strobe    (rel_strobe),
        .periodic_mode (periodic_mode),
        .preset_we     (preset_we),
        .preset_wdata  (preset_wdata),
        .te_we         (te_we),
        .te_wdata      (te_wdata),
        .flag_we       (flag_we),
        .flag_wdata    (flag_wdata),
        .preset_q      (preset_q),
        .count_q       (count_q),
        .te_q          (te_q),
        .flag_q        (flag_q),
        .pend_q        (pend_q)
    );

    pit_irq_shape u_irq (
        .flag_q        (flag_q),
        .pend_q        (pend_q),
        .periodic_mode (periodic_mode),
        .irq_en        (irq_en),
        .irq_drive_low (irq_drive_low)
    );

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_drive_low); // R8
endmodule

// File: tb/interval_timer_irq_tb.sv
// Bench: a reference model of the requirements is stepped once per cycle next to
// the DUT, with directed corner cases followed by random stimulus from a fixed seed.
module interval_timer_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_tick = '0;
    logic       half_fast = 1'b0, half_slow = 1'b0;
    logic [1:0] src_sel = '0;
    logic       periodic_mode = 1'b0, irq_en = 1'b0;
    logic       preset_we = 1'b0;
    logic [7:0] preset_wdata = '0;
    logic       te_we = 1'b0, te_wdata = 1'b0, flag_we = 1'b0, flag_wdata = 1'b0;
    logic [7:0] preset_q, count_q;
    logic       te_q, flag_q, irq_drive_low;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // Reference model state.
    logic [7:0] m_preset, m_count;
    logic       m_te, m_armed, m_startf, m_flag, m_pend;

    always #2 clk = ~clk;

    interval_timer_irq u_dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .half_fast(half_fast),
        .half_slow(half_slow), .src_sel(src_sel), .periodic_mode(periodic_mode),
        .irq_en(irq_en), .preset_we(preset_we), .preset_wdata(preset_wdata),
        .te_we(te_we), .te_wdata(te_wdata), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .preset_q(preset_q), .count_q(count_q), .te_q(te_q), .flag_q(flag_q),
        .irq_drive_low(irq_drive_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic m_irq();
        return irq_en & (periodic_mode ? m_pend : m_flag);
    endfunction

    // Applies the current inputs for one clock edge, advances the model, then compares.
    task automatic step();
        logic tk, rel, start, stop, dec, exp_e, rl;
        logic [7:0] nc;
        tk    = src_tick[src_sel];
        rel   = (src_sel == 2'b00) ? half_fast : half_slow;
        start = te_we & te_wdata & ~m_te;
        stop  = te_we & ~te_wdata;
        dec   = m_te & m_armed & tk & (m_count != 0) & ~preset_we;
        exp_e = dec & (m_count == 8'd1);
        rl    = m_pend & rel & ~preset_we;
        nc    = preset_we ? preset_wdata : rl ? m_preset : dec ? m_count - 8'd1 : m_count;
        if (preset_we) m_preset = preset_wdata;
        m_count = nc;
        if (start) m_te = 1'b1;
        else if (stop) m_te = 1'b0;
        else if (exp_e && !periodic_mode && !m_startf) m_te = 1'b0;
        if (start || stop) m_armed = 1'b0;
        else if (m_te_prev_gate(start, stop) && tk) m_armed = 1'b1;
        if (start) m_startf = m_flag;
        if (exp_e) m_flag = 1'b1;
        else if (flag_we && !flag_wdata) m_flag = 1'b0;
        if (exp_e && periodic_mode) m_pend = 1'b1;
        else if (rel) m_pend = 1'b0;
        @(negedge clk);
        cycles++;
        chk("R2 preset", preset_q, m_preset);
        chk("R3 count", count_q, m_count);
        chk("R5 enable", te_q, m_te);
        chk("R4 flag", flag_q, m_flag);
        chk(periodic_mode ? "R7 irq" : "R6 irq", irq_drive_low, m_irq());
        src_tick = '0; half_fast = 0; half_slow = 0;
        preset_we = 0; te_we = 0; flag_we = 0;
    endtask

    // Arming sees the enable as it was before this edge; a start or stop resets it first.
    logic m_te_before;
    function automatic logic m_te_prev_gate(input logic start, input logic stop);
        return m_te_before & ~start & ~stop;
    endfunction

    task automatic cyc();
        m_te_before = m_te;
        step();
    endtask

    task automatic wr_preset(input logic [7:0] v);
        preset_we = 1; preset_wdata = v; cyc();
    endtask
    task automatic wr_te(input logic v);
        te_we = 1; te_wdata = v; cyc();
    endtask
    task automatic wr_flag(input logic v);
        flag_we = 1; flag_wdata = v; cyc();
    endtask
    task automatic tick(input int b);
        src_tick[b] = 1'b1; cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_preset = 0; m_count = 0; m_te = 0; m_armed = 0; m_startf = 0; m_flag = 0; m_pend = 0;
        // Reset state (R2 R4 R5 R8)
        chk("R2 reset preset", preset_q, 0);
        chk("R3 reset count", count_q, 0);
        chk("R5 reset enable", te_q, 0);
        chk("R4 reset flag", flag_q, 0);
        chk("R8 reset irq", irq_drive_low, 0);

        // R1: only the selected source counts.
        irq_en = 1; periodic_mode = 0; src_sel = 2'b01;
        wr_preset(8'd3);
        wr_te(1);
        tick(0); tick(2); tick(3);
        chk("R1 unselected ticks ignored", count_q, 3);
        tick(1); tick(1);
        chk("R1 selected tick counts after arm", count_q, 2);

        // R10: start and stop with no selected tick between them.
        wr_te(0); wr_te(1); tick(0); wr_te(0);
        chk("R10 short run counts nothing", count_q, 2);
        wr_te(1); tick(1); wr_te(0);
        chk("R10 arming tick counts nothing", count_q, 2);

        // Level expiry (R4 R5 R6 R8).
        wr_preset(8'd2);
        wr_te(1); tick(1); tick(1); tick(1);
        chk("R4 flag set on expiry", flag_q, 1);
        chk("R5 level clears enable", te_q, 0);
        chk("R5 level count holds zero", count_q, 0);
        chk("R6 level irq asserted", irq_drive_low, 1);
        tick(1);
        chk("R6 level irq held", irq_drive_low, 1);
        wr_flag(1);
        chk("R4 writing 1 no effect", flag_q, 1);
        irq_en = 0; cyc();
        chk("R8 masked irq released", irq_drive_low, 0);
        irq_en = 1; cyc();

        // R5: started with flag already set, enable survives expiry.
        wr_preset(8'd1);
        wr_te(1); tick(1); tick(1);
        chk("R5 start with flag keeps enable", te_q, 1);
        chk("R5 count at zero", count_q, 0);
        wr_te(0); wr_flag(0);
        chk("R4 write 0 clears flag", flag_q, 0);
        chk("R6 irq released after clear", irq_drive_low, 0);

        // R7: periodic mode with the 4096 Hz source.
        periodic_mode = 1; src_sel = 2'b00;
        wr_preset(8'd2);
        wr_te(1); tick(0); tick(0); tick(0);
        chk("R7 periodic irq asserted", irq_drive_low, 1);
        chk("R7 count zero before release", count_q, 0);
        half_slow = 1; cyc();
        chk("R7 wrong release strobe ignored", irq_drive_low, 1);
        half_fast = 1; cyc();
        chk("R7 auto release", irq_drive_low, 0);
        chk("R7 reload on release", count_q, 2);
        chk("R7 flag stays set", flag_q, 1);
        chk("R5 periodic keeps enable", te_q, 1);
        wr_te(0);

        // R9: zero preset never expires.
        wr_flag(0);
        wr_preset(8'd0);
        wr_te(1);
        for (int i = 0; i < 20; i++) begin tick(0); half_fast = 1; cyc(); end
        chk("R9 zero preset no flag", flag_q, 0);
        chk("R9 zero preset no irq", irq_drive_low, 0);
        wr_te(0);

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            src_tick  = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
            half_fast = ($urandom_range(0, 7) == 0);
            half_slow = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 63) == 0) src_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 63) == 0) periodic_mode = ~periodic_mode;
            if ($urandom_range(0, 31) == 0) irq_en = ~irq_en;
            if ($urandom_range(0, 47) == 0) begin
                preset_we = 1; preset_wdata = 8'($urandom_range(0, 6));
            end
            if ($urandom_range(0, 23) == 0) begin te_we = 1; te_wdata = ($urandom_range(0, 3) != 0); end
            if ($urandom_range(0, 19) == 0) begin flag_we = 1; flag_wdata = 1'($urandom_range(0, 1)); end
            cyc();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule